// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings a flat panel's four power and signal controls up and down in a fixed order: the logic supply, the pixel data, the secondary supply and the backlight. It inserts a programmable tick count between steps. A host holds `power_req` at the level it wants the panel to reach. When the settled panel state differs from that level, the sequencer runs one complete power-up or power-down. It raises `busy` for the whole run and emits a one-cycle `done` pulse at the end.

The four waits `wait0`..`wait3` are clock-tick counts. Power-up uses them in turn before each of the four turn-on steps. Power-down uses them in mirror order. After a complete power-up the block raises an automatic-sequencing enable (`auto_seq_en`). A software mode hands each of the four outputs to an active-low direct-control bit. It also drops the automatic enable at once, before any software-driven value reaches the outputs.

Top module: `panel_pwr_seq`

## Requirements
- R1: Power-up turns on vdd_en, then data_en, then vee_en, then bl_en, one at a time. With W = wait value, the gaps are W0+1 cycles from the accepting clock edge to vdd_en, W1+1 to data_en, W2+1 to vee_en and W3+1 to bl_en. At every clock, the set of outputs that are on is a prefix of that order.
- R2: A wait of zero makes the next step happen on the following clock, so with all waits zero the four outputs rise on four consecutive clocks.
- R3: Power-down reverses the order. bl_en falls on the clock after acceptance. vee_en falls W3+1 cycles after bl_en, data_en falls W2+1 cycles after vee_en, and vdd_en falls W1+1 cycles after data_en.
- R4: auto_seq_en rises on the clock after bl_en rises at the end of power-up. It falls on the clock after bl_en falls. It is high only while vdd_en, data_en and vee_en are all on.
- R5: busy is high from the clock that accepts a request until the final step. On that final clock busy goes low and done is high for exactly one cycle. The final step is the auto_seq_en rise for power-up and the vdd_en fall for power-down.
- R6: While sw_mode is 1, auto_seq_en is 0 in the same cycle, and power_req is not acted on. From the following clock, {bl_en, vee_en, data_en, vdd_en} equal the inverse of sw_ctl_n[3:0], with bit 0 driving vdd_en and bit 3 driving bl_en, each delayed by one register. A 0 bit means on.
- R7: After reset all five outputs, busy and done are 0 and the panel is treated as off.
- R8: A change of power_req during a run does not disturb the run. If power_req still differs from the new settled state, the opposite sequence is accepted on the clock after done, so the two never interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| power_req | input | 1 | Wanted panel state, 1 = on |
| sw_mode | input | 1 | 1 = outputs under direct software control |
| sw_ctl_n | input | 4 | Active-low direct controls {bl, vee, data, vdd} |
| wait0 | input | DW | Ticks before vdd turn-on |
| wait1 | input | DW | Ticks between vdd and data |
| wait2 | input | DW | Ticks between data and vee |
| wait3 | input | DW | Ticks between vee and backlight |
| vdd_en | output | 1 | Logic supply enable |
| data_en | output | 1 | Pixel data enable |
| vee_en | output | 1 | Secondary supply enable |
| bl_en | output | 1 | Backlight enable |
| auto_seq_en | output | 1 | Automatic sequencing enable, active-high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case is a request that reverses direction while a run is in flight. The turn-around must land exactly one clock after done, with no overlap. The stimulus drops power_req a few cycles into a power-up. The scoreboard then expects the full rest of the power-up, one idle done cycle, and a power-down starting on the next clock. A second hard case is entering software mode while the panel is fully on. The bench samples between the sw_mode change and the next clock edge to see auto_seq_en drop while the sequencer's own outputs are still shown.

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          power_req,
  input  logic          sw_mode,
  input  logic [3:0]    sw_ctl_n,
  input  logic [DW-1:0] wait0,
  input  logic [DW-1:0] wait1,
  input  logic [DW-1:0] wait2,
  input  logic [DW-1:0] wait3,
  output logic          vdd_en,
  output logic          data_en,
  output logic          vee_en,
  output logic          bl_en,
  output logic          auto_seq_en,
  output logic          busy,
  output logic          done
);
  localparam logic [2:0] LAST_UP = 3'd4;
  localparam logic [2:0] LAST_DN = 3'd3;

  typedef enum logic {ST_IDLE, ST_RUN} st_t;

  st_t           st;
  logic          up_q, on_q, seq_q, busy_q, done_q, sw_q;
  logic [2:0]    step;
  logic [DW-1:0] cnt;
  logic [3:0]    rails, swc_q;

  function automatic logic [DW-1:0] dly(input logic up, input logic [2:0] k);
    if (up) begin
      case (k)
        3'd0:    return wait0;
        3'd1:    return wait1;
        3'd2:    return wait2;
        3'd3:    return wait3;
        default: return '0;
      endcase
    end else begin
      case (k)
        3'd1:    return wait3;
        3'd2:    return wait2;
        3'd3:    return wait1;
        default: return '0;
      endcase
    end
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      up_q   <= 1'b0;
      on_q   <= 1'b0;
      seq_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step   <= '0;
      cnt    <= '0;
      rails  <= '0;
    end else begin
      done_q <= 1'b0;
      seq_q  <= seq_q & rails[3];
      case (st)
        ST_IDLE: begin
          if (!sw_mode && power_req != on_q) begin
            st     <= ST_RUN;
            up_q   <= power_req;
            step   <= '0;
            cnt    <= dly(power_req, 3'd0);
            busy_q <= 1'b1;
          end
        end
        ST_RUN: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (up_q) begin
            if (step == LAST_UP) begin
              seq_q  <= 1'b1;
              on_q   <= 1'b1;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              rails[step[1:0]] <= 1'b1;
              step <= step + 3'd1;
              cnt  <= dly(1'b1, step + 3'd1);
            end
          end else begin
            rails[2'd3 - step[1:0]] <= 1'b0;
            if (step == LAST_DN) begin
              on_q   <= 1'b0;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              step <= step + 3'd1;
              cnt  <= dly(1'b0, step + 3'd1);
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      swc_q <= 4'hF;
    end else begin
      sw_q  <= sw_mode;
      swc_q <= sw_ctl_n;
    end
  end

  assign {bl_en, vee_en, data_en, vdd_en} = sw_q ? ~swc_q : rails;
  assign auto_seq_en = seq_q & ~sw_mode;
  assign busy = busy_q;
  assign done = done_q;

  AST_RAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rails & (rails + 4'd1)) == 4'd0); // R1
  AST_AUTO_NEEDS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q |-> (&rails[2:0])); // R4
  AST_AUTO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q && !rails[3]) |=> !seq_q); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(rails)); // R5
  AST_SW_AUTO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_q) |-> !$past(auto_seq_en)); // R6
endmodule

// File: tb/test_panel_pwr_seq.sv
`timescale 1ns/100ps
module test_panel_pwr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        power_req = 1'b0;
  logic        sw_mode = 1'b0;
  logic [3:0]  sw_ctl_n = 4'hF;
  logic [15:0] w0 = '0, w1 = '0, w2 = '0, w3 = '0;
  logic        vdd_en, data_en, vee_en, bl_en, auto_seq_en, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int         t;
    logic [4:0] o;
    logic       b;
    logic       d;
    string      tag;
  } exp_t;
  exp_t q[$];

  panel_pwr_seq i_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .power_req(power_req), .sw_mode(sw_mode),
    .sw_ctl_n(sw_ctl_n), .wait0(w0), .wait1(w1), .wait2(w2), .wait3(w3),
    .vdd_en(vdd_en), .data_en(data_en), .vee_en(vee_en), .bl_en(bl_en),
    .auto_seq_en(auto_seq_en), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wire [4:0] outs = {auto_seq_en, bl_en, vee_en, data_en, vdd_en};

  task automatic check(string tag, logic [4:0] eo, logic eb, logic ed);
    checks++;
    if (outs !== eo || busy !== eb || done !== ed) begin
      errors++;
      $display("FAIL %s cyc %0d: o=%b busy=%b done=%b expected o=%b busy=%b done=%b",
               tag, cyc, outs, busy, done, eo, eb, ed);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].t <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.t < cyc) begin
        checks++; errors++;
        $display("FAIL %s missed slot %0d expected o=%b", e.tag, e.t, e.o);
      end else check(e.tag, e.o, e.b, e.d);
    end
  end

  task automatic push(int t, logic [4:0] o, logic b, logic d, string tag);
    exp_t e;
    e.t = t; e.o = o; e.b = b; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_up(int e0, string tag, output int tend);
    int t1, t2, t3, t4, t5;
    t1 = e0 + int'(w0) + 1; t2 = t1 + int'(w1) + 1;
    t3 = t2 + int'(w2) + 1; t4 = t3 + int'(w3) + 1; t5 = t4 + 1;
    for (int t = e0; t <= t5; t++) begin
      logic [4:0] o;
      if (t < t1) o = 5'b00000;
      else if (t < t2) o = 5'b00001;
      else if (t < t3) o = 5'b00011;
      else if (t < t4) o = 5'b00111;
      else if (t < t5) o = 5'b01111;
      else o = 5'b11111;
      if (t == t5) push(t, o, 1'b0, 1'b1, "R5");
      else push(t, o, 1'b1, 1'b0, (t == t4) ? "R4" : tag);
    end
    tend = t5;
  endtask

  task automatic push_down(int e0, string tag, output int tend);
    int t1, tv, tdt, tq;
    t1 = e0 + 1; tv = t1 + int'(w3) + 1;
    tdt = tv + int'(w2) + 1; tq = tdt + int'(w1) + 1;
    for (int t = e0; t <= tq; t++) begin
      logic [4:0] o;
      if (t < t1) o = 5'b11111;
      else if (t < tv) o = (t == t1) ? 5'b10111 : 5'b00111;
      else if (t < tdt) o = 5'b00011;
      else if (t < tq) o = 5'b00001;
      else o = 5'b00000;
      if (t == tq) push(t, o, 1'b0, 1'b1, "R5");
      else push(t, o, 1'b1, 1'b0, (t == t1 + 1) ? "R4" : tag);
    end
    tend = tq;
  endtask

  task automatic set_waits(int a, int b, int c, int d);
    w0 = 16'(a); w1 = 16'(b); w2 = 16'(c); w3 = 16'(d);
  endtask

  task automatic run(logic dir, string tag);
    int tend;
    @(negedge clk); #1;
    power_req = dir;
    if (dir) push_up(cyc + 1, tag, tend);
    else push_down(cyc + 1, tag, tend);
    push(tend + 1, dir ? 5'b11111 : 5'b00000, 1'b0, 1'b0, "R5");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int tend, tend2;
    repeat (3) @(negedge clk);
    check("R7", 5'b00000, 1'b0, 1'b0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", 5'b00000, 1'b0, 1'b0);

    set_waits(3, 2, 4, 1);
    run(1'b1, "R1");
    run(1'b0, "R3");

    set_waits(0, 0, 0, 0);
    run(1'b1, "R2");
    run(1'b0, "R2");

    set_waits(1, 5, 0, 2);
    run(1'b1, "R1");
    run(1'b0, "R3");

    // R8: reverse the request mid power-up
    set_waits(2, 1, 1, 1);
    @(negedge clk); #1;
    power_req = 1'b1;
    push_up(cyc + 1, "R8", tend);
    repeat (3) @(negedge clk);
    #1 power_req = 1'b0;
    push_down(tend + 1, "R8", tend2);
    push(tend2 + 1, 5'b00000, 1'b0, 1'b0, "R8");
    wait (q.size() == 0);
    repeat (2) @(negedge clk);

    // R6: software mode while fully on
    set_waits(0, 0, 0, 0);
    run(1'b1, "R1");
    @(negedge clk); #1;
    sw_mode = 1'b1; sw_ctl_n = 4'b1010;
    #1 check("R6", 5'b01111, 1'b0, 1'b0);
    @(negedge clk); #1;
    check("R6", 5'b00101, 1'b0, 1'b0);
    power_req = 1'b0;
    repeat (4) @(negedge clk);
    #1 check("R6", 5'b00101, 1'b0, 1'b0);
    power_req = 1'b1; sw_ctl_n = 4'b0000;
    @(negedge clk); #1;
    check("R6", 5'b01111, 1'b0, 1'b0);
    sw_mode = 1'b0;
    @(negedge clk); #1;
    check("R6", 5'b11111, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    #1 check("R6", 5'b11111, 1'b0, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule